// File: doc/BRIEF.md
# Dual-Clock FIFO with Misuse Monitors

This block carries 16-bit words from one clock domain to an unrelated one through a 16-entry buffer. The producer pulses a write strobe with data on its own clock and watches a full flag. The consumer sees the oldest stored word on its data output whenever the buffer is not empty. A read strobe retires that word and advances to the next one.

Each side keeps a binary pointer one bit wider than the address. It also keeps the Gray form of that pointer, computed and registered in its own domain. Only the Gray form goes through a two-stage synchronizer to the other domain. Full is computed in the write domain and empty in the read domain, each from its own pointer and the synchronized pointer of the other side.

A strobe that arrives while full, or while empty, is dropped: the pointers and the storage stay as they were. It also sets a sticky error flag in the domain where the misuse occurred. That flag clears only through that domain's active-low reset.

Top module: `dual_clock_fifo`

## Requirements
- R1: Once a domain's reset is released, that domain's outputs start in these states: the write side has wr_full 0 and wr_err 0, and the read side has rd_empty 1 and rd_err 0.
- R2: Words leave in the order they were written. While rd_empty is 0, rd_data shows the oldest unread word, and the Nth accepted read retires the Nth accepted write.
- R3: wr_full is 1 from the write clock edge that stores the 16th unread word. Before that edge it is 0.
- R4: A write strobe while wr_full is 1 is not accepted. Neither the write pointer nor any stored word changes, so a later drain returns exactly the 16 words written earlier.
- R5: A write strobe while wr_full is 1 sets wr_err at that write clock edge, and wr_err then stays 1 until the write reset.
- R6: A read strobe while rd_empty is 1 is not accepted and sets rd_err at that read clock edge. rd_err then stays 1 until the read reset.
- R7: rd_empty becomes 1 at the read clock edge that retires the last stored word. It returns to 0 within a few read clocks after a write.
- R8: Each pointer crosses domains in Gray code, and its registered Gray value changes in at most one bit per clock of its own domain.
- R9: After reset, wr_full and rd_empty are never unknown, and rd_data is defined on every accepted read.
- R10: The write reset clears wr_err without changing rd_err. The read reset clears rd_err and sets rd_empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_inc | input | 1 | Write strobe |
| wr_data | input | 16 | Word to store |
| wr_full | output | 1 | Buffer holds 16 unread words |
| wr_err | output | 1 | Sticky: write attempted while full |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_inc | input | 1 | Read strobe, retires the shown word |
| rd_data | output | 16 | Oldest unread word |
| rd_empty | output | 1 | No unread word |
| rd_err | output | 1 | Sticky: read attempted while empty |

## Verification
The hardest state to reach from the ports is the one where the two clocks run at unrelated rates and both strobes are active while the buffer sits at its limits. In that state full or empty is already stale through the synchronizer. The stimulus covers it in two ways. One is a concurrent producer and consumer on clocks of 4 ns and 7 ns, with the faster writer repeatedly pinning the buffer at full. The other is a sweep over every fill level from 1 to 16, where the write burst and the drain are separated. Deliberate strobes at full and at empty then check that nothing moves and that the error flags latch.

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_inc,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_err,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_inc,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic          rd_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, wbin_nx, wgray_nx;
  logic [PW-1:0] rbin, rgray, rbin_nx, rgray_nx;
  logic [PW-1:0] rg_w1, rg_w2;
  logic [PW-1:0] wg_r1, wg_r2;

  logic wr_take, rd_take;

  assign wr_take  = wr_inc & ~wr_full;
  assign rd_take  = rd_inc & ~rd_empty;

  assign wbin_nx  = wbin + PW'(wr_take);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign rbin_nx  = rbin + PW'(rd_take);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);

  always_ff @(posedge wr_clk)
    if (wr_take) mem[wbin[AW-1:0]] <= wr_data;

  assign rd_data = mem[rbin[AW-1:0]];

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      rg_w1   <= '0;
      rg_w2   <= '0;
      wr_full <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      rg_w1   <= rgray;
      rg_w2   <= rg_w1;
      wr_full <= (wgray_nx == {~rg_w2[PW-1:PW-2], rg_w2[PW-3:0]});
      wr_err  <= wr_err | (wr_inc & wr_full);
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wg_r1    <= '0;
      wg_r2    <= '0;
      rd_empty <= 1'b1;
      rd_err   <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      wg_r1    <= wgray;
      wg_r2    <= wg_r1;
      rd_empty <= (rgray_nx == wg_r2);
      rd_err   <= rd_err | (rd_inc & rd_empty);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_inc && wr_full) |=> (wbin == $past(wbin)));

  // R5
  wr_err_set_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_inc && wr_full) |=> wr_err);

  // R5
  wr_err_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_err |=> wr_err);

  // R6
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_inc && rd_empty) |=> (rbin == $past(rbin)) && rd_err);

  // R6
  rd_err_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_err |=> rd_err);

  // R8
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

  // R8
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

  // R9
  full_known_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !$isunknown(wr_full));

  // R9
  empty_known_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !$isunknown(rd_empty) && (!(rd_inc && !rd_empty) || !$isunknown(rd_data)));

  // R7
  drain_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_take && (rgray_nx == wg_r2) && $stable(wg_r2)) |=> rd_empty);
endmodule

// File: tb/sim_dual_clock_fifo.sv
module sim_dual_clock_fifo;
  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_inc = 0, rd_inc = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic wr_full, wr_err, rd_empty, rd_err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dual_clock_fifo u0 (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_inc(wr_inc), .wr_data(wr_data),
    .wr_full(wr_full), .wr_err(wr_err),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_inc(rd_inc), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_err(rd_err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge wr_clk);
    wr_inc = 1; wr_data = v;
    @(negedge wr_clk);
    wr_inc = 0;
  endtask

  task automatic pop_check(input logic [15:0] exp, input string tag);
    @(negedge rd_clk);
    check(!rd_empty, tag, rd_empty, 0);
    check(rd_data == exp, tag, rd_data, exp);
    rd_inc = 1;
    @(negedge rd_clk);
    rd_inc = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (2) @(negedge rd_clk);
    // R1
    check(wr_full == 0, "R1 wr_full", wr_full, 0);
    check(wr_err == 0,  "R1 wr_err", wr_err, 0);
    check(rd_empty == 1, "R1 rd_empty", rd_empty, 1);
    check(rd_err == 0,  "R1 rd_err", rd_err, 0);

    // R3 fill to the limit
    for (int i = 0; i < 16; i++) begin
      push(16'h5000 + 16'(i));
      if (i == 14) check(wr_full == 0, "R3 not full at 15", wr_full, 0);
    end
    check(wr_full == 1, "R3 full at 16", wr_full, 1);

    // R4 R5 overflow attempt
    push(16'hDEAD);
    check(wr_err == 1, "R5 wr_err set", wr_err, 1);
    check(wr_full == 1, "R4 still full", wr_full, 1);
    repeat (5) @(negedge wr_clk);
    check(wr_err == 1, "R5 wr_err sticky", wr_err, 1);

    // R2 R4 drain shows original words only
    settle();
    for (int i = 0; i < 16; i++) pop_check(16'h5000 + 16'(i), "R4 drain order");
    // R7
    check(rd_empty == 1, "R7 empty after drain", rd_empty, 1);

    // R6 underflow attempt
    @(negedge rd_clk);
    rd_inc = 1;
    @(negedge rd_clk);
    rd_inc = 0;
    check(rd_err == 1, "R6 rd_err set", rd_err, 1);
    check(rd_empty == 1, "R6 still empty", rd_empty, 1);
    repeat (4) @(negedge rd_clk);
    check(rd_err == 1, "R6 rd_err sticky", rd_err, 1);
    settle();
    check(wr_full == 0, "R3 full clears after drain", wr_full, 0);

    // R2 R7 sweep every fill level
    for (int k = 1; k <= 16; k++) begin
      for (int i = 0; i < k; i++) push(16'(k * 256 + i * 3));
      check(wr_full == (k == 16), "R3 full at level", wr_full, int'(k == 16));
      settle();
      check(rd_empty == 0, "R7 empty clears after write", rd_empty, 0);
      for (int i = 0; i < k; i++) pop_check(16'(k * 256 + i * 3), "R2 sweep order");
      check(rd_empty == 1, "R7 empty after level drain", rd_empty, 1);
      settle();
    end

    // R2 concurrent producer and consumer
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          @(negedge wr_clk);
          while (wr_full) @(negedge wr_clk);
          wr_inc = 1; wr_data = 16'hA000 + 16'(i);
          @(negedge wr_clk);
          wr_inc = 0;
        end
      end
      begin
        for (int i = 0; i < 60; i++) begin
          @(negedge rd_clk);
          while (rd_empty) @(negedge rd_clk);
          check(rd_data == 16'hA000 + 16'(i), "R2 concurrent order", rd_data, 16'hA000 + i);
          rd_inc = 1;
          @(negedge rd_clk);
          rd_inc = 0;
        end
      end
    join
    @(negedge rd_clk);
    check(rd_empty == 1, "R7 empty after stream", rd_empty, 1);

    // R10 per-domain reset of error flags
    @(negedge wr_clk);
    wr_rst_n = 0;
    @(negedge wr_clk);
    check(wr_err == 0, "R10 wr_err cleared", wr_err, 0);
    check(rd_err == 1, "R10 rd_err kept", rd_err, 1);
    @(negedge rd_clk);
    rd_rst_n = 0;
    @(negedge rd_clk);
    check(rd_err == 0, "R10 rd_err cleared", rd_err, 0);
    check(rd_empty == 1, "R10 rd_empty set", rd_empty, 1);
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
    push(16'h1234);
    settle();
    pop_check(16'h1234, "R10 transfer after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule